// File: doc/BRIEF.md
# Half-Second Watchdog with Pre-Timeout and Power-Down Counter

This block is a system watchdog paced by a 2 Hz timebase. A single-cycle enable arrives every half second, and each such pulse counts as one tick. The main counter counts ticks since the last reload. When it reaches the programmed limit, a sticky reset request goes high. An optional pre-timeout interrupt warns software a programmable number of ticks before that point. Software keeps the system alive with a two-word service sequence. That sequence restarts the count and clears any pending warning.

Two configuration bits set whether ticks count while the system is in low-power mode and while it is in debug mode. A separate power-down counter starts from every reset and runs for a fixed 16 s. When it expires, it pulls a low-active output. Software can prevent this through a disable that can be written only once per reset. Register decode and timebase generation sit outside the block. Configuration arrives as plain inputs.

Top module: `halfsec_watchdog`

## Requirements
- R1: While and after reset, before any tick: `wdRst` = 0, `preIrq` = 0, `pdOutN` = 1.
- R2: `cfgTimeout` value N (8 bits) gives a period of N+1 counted ticks. `wdRst` rises at the clock edge that accepts the (N+1)-th counted tick since the last reload or reset, and not before.
- R3: Once high, `wdRst` stays high until `rstN` is asserted. Service writes and further ticks do not clear it.
- R4: With `cfgIntEn` = 1 and `cfgPreInt` value M (8 bits), `preIrq` rises at the counted tick that leaves M or fewer ticks before expiry. When M = 0, this is the same edge on which `wdRst` rises. With `cfgIntEn` = 0, `preIrq` stays 0.
- R5: A service write of 0x5555 followed by a service write of 0xAAAA restarts the timeout count from zero and clears `preIrq` on the edge that accepts 0xAAAA.
- R6: A service write of any value other than 0x5555 or 0xAAAA between the two words cancels the sequence. A 0xAAAA with no armed 0x5555 before it has no effect on the count.
- R7: A tick is not counted when `wdEn` = 0, when `lowPwrMode` = 1 with `cfgRunLowPwr` = 0, or when `debugMode` = 1 with `cfgRunDebug` = 0.
- R8: The power-down counter counts every tick from reset, regardless of `wdEn` and the mode inputs. At the 32nd tick, `pdOutN` goes low and stays low until reset, unless the counter was disabled first.
- R9: The first `pdDisWrite` after reset locks `pdDisVal` as the disable setting (1 = disabled). Later writes are ignored until the next reset.
- R10: When a completing 0xAAAA write and a tick arrive in the same cycle, the reload wins, and the count is zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle pulse every 0.5 s |
| wdEn | input | 1 | Watchdog counting enable |
| cfgTimeout | input | 8 | Timeout N, period (N+1) x 0.5 s |
| cfgPreInt | input | 8 | Pre-timeout lead M, M x 0.5 s |
| cfgIntEn | input | 1 | Pre-timeout interrupt enable |
| cfgRunLowPwr | input | 1 | Keep counting in low-power mode |
| cfgRunDebug | input | 1 | Keep counting in debug mode |
| lowPwrMode | input | 1 | System is in low-power mode |
| debugMode | input | 1 | System is in debug mode |
| svcWrite | input | 1 | Service word write strobe |
| svcData | input | 16 | Service word |
| pdDisWrite | input | 1 | Power-down disable write strobe |
| pdDisVal | input | 1 | Power-down disable value |
| wdRst | output | 1 | Sticky reset request |
| preIrq | output | 1 | Pre-timeout interrupt |
| pdOutN | output | 1 | Low-active power-down expiry |

## Verification
A wrong tick count or a mis-gated tick shows up at once: `wdRst` or `preIrq` rises one tick early or late, and the bench sees this within a few half-second ticks. A broken service checker shows up as a reload that should not happen, or one that is missed. Either way, `wdRst` moves by a known number of ticks. A wrong lock or count in the power-down counter shows up as `pdOutN` falling at the wrong tick, or not falling at all, within 32 ticks of reset.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic reload;      // valid service sequence completed
    logic count;       // tick accepted by the timeout counter
    logic pdCount;     // tick seen by the power-down counter
    logic pdDisabled;  // locked power-down disable setting
  } hswStrobes_t;
endpackage

// File: rtl/hsw_ctrl.sv
module hsw_ctrl
  import hsw_pkg::*;
#(
  parameter int KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY_ARM = 16'h5555,
  parameter logic [KEY_W-1:0] KEY_FIRE = 16'hAAAA
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             wdEn,
  input  logic             cfgRunLowPwr,
  input  logic             cfgRunDebug,
  input  logic             lowPwrMode,
  input  logic             debugMode,
  input  logic             svcWrite,
  input  logic [KEY_W-1:0] svcData,
  input  logic             pdDisWrite,
  input  logic             pdDisVal,
  output hswStrobes_t      strobes
);

  logic armed;
  logic pdLocked;
  logic pdDisabled;
  logic modeAllows;

  // Service sequence: first key arms, second key fires, anything else disarms
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (svcWrite) begin
      armed <= (svcData == KEY_ARM);
    end
  end

  // Write-once power-down disable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdLocked   <= 1'b0;
      pdDisabled <= 1'b0;
    end else if (pdDisWrite && !pdLocked) begin
      pdLocked   <= 1'b1;
      pdDisabled <= pdDisVal;
    end
  end

  always_comb begin
    modeAllows = wdEn && (!lowPwrMode || cfgRunLowPwr) && (!debugMode || cfgRunDebug);
    strobes.reload     = svcWrite && armed && (svcData == KEY_FIRE);
    strobes.count      = tickEn && modeAllows;
    strobes.pdCount    = tickEn;
    strobes.pdDisabled = pdDisabled;
  end

  // R9: once locked, the disable setting never changes until reset
  p_lock_once_r9: assert property (@(posedge clk) disable iff (!rstN)
    pdLocked |=> (pdLocked && $stable(pdDisabled)));

endmodule

// File: rtl/hsw_datapath.sv
module hsw_datapath
  import hsw_pkg::*;
#(
  parameter int TO_W = 8,
  parameter int PD_TICKS = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  hswStrobes_t     strobes,
  input  logic [TO_W-1:0] cfgTimeout,
  input  logic [TO_W-1:0] cfgPreInt,
  input  logic            cfgIntEn,
  output logic            wdRst,
  output logic            preIrq,
  output logic            pdOutN
);

  localparam int EW = TO_W + 1;
  localparam int PW = $clog2(PD_TICKS + 1);
  localparam logic [PW-1:0] PD_LAST = PW'(PD_TICKS - 1);

  logic [EW-1:0] elapsed;
  logic [EW-1:0] elapsedNext;
  logic [EW-1:0] limit;
  logic [EW:0]   reachSum;
  logic          tickHit;
  logic          wdRstQ;
  logic          preIrqQ;
  logic [PW-1:0] pdCnt;
  logic          pdExp;

  always_comb begin
    elapsedNext = elapsed + EW'(1);
    limit       = {1'b0, cfgTimeout} + EW'(1);
    reachSum    = {1'b0, elapsedNext} + {2'b00, cfgPreInt};
    tickHit     = strobes.count && !strobes.reload && !wdRstQ;
  end

  // Timeout counter: reload has priority over a tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      elapsed <= '0;
    end else if (strobes.reload) begin
      elapsed <= '0;
    end else if (tickHit) begin
      elapsed <= elapsedNext;
    end
  end

  // Sticky reset request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdRstQ <= 1'b0;
    end else if (tickHit && (elapsedNext >= limit)) begin
      wdRstQ <= 1'b1;
    end
  end

  // Pre-timeout interrupt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preIrqQ <= 1'b0;
    end else if (strobes.reload) begin
      preIrqQ <= 1'b0;
    end else if (tickHit && cfgIntEn && (reachSum >= {1'b0, limit})) begin
      preIrqQ <= 1'b1;
    end
  end

  // Fixed-period power-down counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdCnt <= '0;
      pdExp <= 1'b0;
    end else if (strobes.pdCount && !strobes.pdDisabled && !pdExp) begin
      pdCnt <= pdCnt + PW'(1);
      if (pdCnt == PD_LAST) pdExp <= 1'b1;
    end
  end

  assign wdRst  = wdRstQ;
  assign preIrq = preIrqQ;
  assign pdOutN = !pdExp;

  // R3: reset request is sticky
  p_rst_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    wdRstQ |=> wdRstQ);
  // R8: power-down output stays low once asserted
  p_pd_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    pdExp |=> pdExp);
  // R5: a completed service sequence leaves no pending interrupt
  p_reload_clears_irq_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reload |=> !preIrqQ);
  // R7: without an accepted tick or reload the count holds
  p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.count && !strobes.reload) |=> $stable(elapsed));

endmodule

// File: rtl/halfsec_watchdog.sv
module halfsec_watchdog
  import hsw_pkg::*;
#(
  parameter int TO_W = 8,
  parameter int PD_TICKS = 32,
  parameter int KEY_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             wdEn,
  input  logic [TO_W-1:0]  cfgTimeout,
  input  logic [TO_W-1:0]  cfgPreInt,
  input  logic             cfgIntEn,
  input  logic             cfgRunLowPwr,
  input  logic             cfgRunDebug,
  input  logic             lowPwrMode,
  input  logic             debugMode,
  input  logic             svcWrite,
  input  logic [KEY_W-1:0] svcData,
  input  logic             pdDisWrite,
  input  logic             pdDisVal,
  output logic             wdRst,
  output logic             preIrq,
  output logic             pdOutN
);

  hswStrobes_t strobes;

  hsw_ctrl #(
    .KEY_W   (KEY_W),
    .KEY_ARM (KEY_W'(16'h5555)),
    .KEY_FIRE(KEY_W'(16'hAAAA))
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .tickEn      (tickEn),
    .wdEn        (wdEn),
    .cfgRunLowPwr(cfgRunLowPwr),
    .cfgRunDebug (cfgRunDebug),
    .lowPwrMode  (lowPwrMode),
    .debugMode   (debugMode),
    .svcWrite    (svcWrite),
    .svcData     (svcData),
    .pdDisWrite  (pdDisWrite),
    .pdDisVal    (pdDisVal),
    .strobes     (strobes)
  );

  hsw_datapath #(
    .TO_W    (TO_W),
    .PD_TICKS(PD_TICKS)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .cfgTimeout(cfgTimeout),
    .cfgPreInt (cfgPreInt),
    .cfgIntEn  (cfgIntEn),
    .wdRst     (wdRst),
    .preIrq    (preIrq),
    .pdOutN    (pdOutN)
  );

endmodule

// File: tb/halfsec_watchdog_tb.sv
`timescale 1ns/1ps
module halfsec_watchdog_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wdEn = 1'b1;
  logic [7:0]  cfgTimeout = 8'd0;
  logic [7:0]  cfgPreInt = 8'd0;
  logic        cfgIntEn = 1'b0;
  logic        cfgRunLowPwr = 1'b0;
  logic        cfgRunDebug = 1'b0;
  logic        lowPwrMode = 1'b0;
  logic        debugMode = 1'b0;
  logic        svcWrite = 1'b0;
  logic [15:0] svcData = 16'h0;
  logic        pdDisWrite = 1'b0;
  logic        pdDisVal = 1'b0;
  logic        wdRst, preIrq, pdOutN;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  halfsec_watchdog dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wdEn(wdEn),
    .cfgTimeout(cfgTimeout), .cfgPreInt(cfgPreInt), .cfgIntEn(cfgIntEn),
    .cfgRunLowPwr(cfgRunLowPwr), .cfgRunDebug(cfgRunDebug),
    .lowPwrMode(lowPwrMode), .debugMode(debugMode),
    .svcWrite(svcWrite), .svcData(svcData),
    .pdDisWrite(pdDisWrite), .pdDisVal(pdDisVal),
    .wdRst(wdRst), .preIrq(preIrq), .pdOutN(pdOutN)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    tickEn = 0; wdEn = 1; cfgTimeout = 0; cfgPreInt = 0; cfgIntEn = 0;
    cfgRunLowPwr = 0; cfgRunDebug = 0; lowPwrMode = 0; debugMode = 0;
    svcWrite = 0; svcData = 0; pdDisWrite = 0; pdDisVal = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic svc(input logic [15:0] v);
    @(negedge clk); svcWrite = 1'b1; svcData = v;
    @(negedge clk); svcWrite = 1'b0;
  endtask

  task automatic pdDis(input logic v);
    @(negedge clk); pdDisWrite = 1'b1; pdDisVal = v;
    @(negedge clk); pdDisWrite = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    chk("R1 wdRst after reset", wdRst, 1'b0);
    chk("R1 preIrq after reset", preIrq, 1'b0);
    chk("R1 pdOutN after reset", pdOutN, 1'b1);
  endtask

  task automatic testTimeoutSticky();
    doReset();
    cfgTimeout = 8'd3;
    tick(3);
    chk("R2 no expiry after N ticks", wdRst, 1'b0);
    tick(1);
    chk("R2 expiry at N+1 ticks", wdRst, 1'b1);
    chk("R4 no irq when disabled", preIrq, 1'b0);
    svc(16'h5555); svc(16'hAAAA); tick(2);
    chk("R3 reset request sticky", wdRst, 1'b1);
    doReset();
    chk("R3 cleared by reset", wdRst, 1'b0);
  endtask

  task automatic testPreIrqService();
    doReset();
    cfgTimeout = 8'd5; cfgPreInt = 8'd2; cfgIntEn = 1'b1;
    tick(3);
    chk("R4 irq not yet", preIrq, 1'b0);
    tick(1);
    chk("R4 irq at M remaining", preIrq, 1'b1);
    chk("R4 no reset yet", wdRst, 1'b0);
    svc(16'h5555); svc(16'hAAAA);
    chk("R5 service clears irq", preIrq, 1'b0);
    tick(5);
    chk("R5 reload restarted count", wdRst, 1'b0);
    tick(1);
    chk("R5 expiry after full reloaded period", wdRst, 1'b1);
  endtask

  task automatic testZeroLead();
    doReset();
    cfgTimeout = 8'd2; cfgPreInt = 8'd0; cfgIntEn = 1'b1;
    tick(2);
    chk("R4 M=0 irq not early", preIrq, 1'b0);
    tick(1);
    chk("R4 M=0 irq with timeout", preIrq, 1'b1);
    chk("R2 timeout with M=0", wdRst, 1'b1);
  endtask

  task automatic testBrokenSeq();
    doReset();
    cfgTimeout = 8'd3;
    tick(2);
    svc(16'h5555); svc(16'h1234); svc(16'hAAAA);
    svc(16'hAAAA);
    tick(1);
    chk("R6 no reload, not yet expired", wdRst, 1'b0);
    tick(1);
    chk("R6 cancelled sequence did not reload", wdRst, 1'b1);
  endtask

  task automatic testGating();
    doReset();
    cfgTimeout = 8'd1;
    wdEn = 1'b0; tick(5);
    chk("R7 disabled ignores ticks", wdRst, 1'b0);
    wdEn = 1'b1; lowPwrMode = 1'b1; tick(2);
    chk("R7 low-power stop", wdRst, 1'b0);
    lowPwrMode = 1'b0; debugMode = 1'b1; tick(2);
    chk("R7 debug stop", wdRst, 1'b0);
    debugMode = 1'b0; lowPwrMode = 1'b1; cfgRunLowPwr = 1'b1;
    tick(1);
    chk("R7 low-power run one tick", wdRst, 1'b0);
    tick(1);
    chk("R7 low-power run expires", wdRst, 1'b1);
  endtask

  task automatic testPowerDown();
    doReset();
    wdEn = 1'b0;
    tick(31);
    chk("R8 pd not yet at 31", pdOutN, 1'b1);
    tick(1);
    chk("R8 pd low at 32", pdOutN, 1'b0);
    pdDis(1'b1); tick(1);
    chk("R8 pd stays low", pdOutN, 1'b0);
  endtask

  task automatic testWriteOnce();
    doReset();
    wdEn = 1'b0;
    pdDis(1'b0); pdDis(1'b1);
    tick(32);
    chk("R9 second write ignored", pdOutN, 1'b0);
    doReset();
    wdEn = 1'b0;
    pdDis(1'b1); pdDis(1'b0);
    tick(40);
    chk("R9 disable locked in", pdOutN, 1'b1);
  endtask

  task automatic testPriority();
    doReset();
    cfgTimeout = 8'd1;
    tick(1);
    svc(16'h5555);
    @(negedge clk); tickEn = 1'b1; svcWrite = 1'b1; svcData = 16'hAAAA;
    @(negedge clk); tickEn = 1'b0; svcWrite = 1'b0;
    chk("R10 reload wins over tick", wdRst, 1'b0);
    tick(1);
    chk("R10 count restarted at zero", wdRst, 1'b0);
    tick(1);
    chk("R10 expiry after full period", wdRst, 1'b1);
  endtask

  initial begin
    testReset();
    testTimeoutSticky();
    testPreIrqService();
    testZeroLead();
    testBrokenSeq();
    testGating();
    testPowerDown();
    testWriteOnce();
    testPriority();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule